// File: doc/BRIEF.md
# Register-File ALU Slice with Sign Condition Codes

This block is the execute slice of a small 16-bit load/store processor. It holds eight general-purpose registers with two combinational read ports and one synchronous write port. The two read values feed a four-function ALU. The second operand can instead be a sign-extended 5-bit immediate taken from the instruction. Every cycle the ALU result is offered both as the data for the register write and as the block's main output.

A three-bit condition register records whether the last loaded result was negative, zero or positive, reading it as two's complement. Exactly one of the three bits is ever set. The slice also presents the result plus one on a separate output, so that a program-counter path can use it.

Decode, sequencing, memory and the program counter all sit outside. The controller drives the register addresses, the operation select, the operand-B source, the write enable and the condition-load enable on every cycle.

Top module: `exec_slice`

## Requirements
- R1: While reset is held, and after it is released, every register reads back as zero and the flags read N=0, Z=1, P=0.
- R2: Operation select 00 gives A plus B, wrapped modulo 2^16, with no carry or overflow output.
- R3: Operation select 01 gives the bitwise AND of A and B.
- R4: Operation select 10 gives the bitwise complement of A, and operand B has no effect on the result.
- R5: Operation select 11 passes operand A to the result unchanged.
- R6: When `b_imm_sel` is 1, operand B is the 5-bit immediate sign-extended from its bit 4. When it is 0, operand B is the value read at `rd_b_addr`.
- R7: With `wr_en` high, the ALU result is written into register `wr_addr` on the rising clock edge. A read of that register in the same cycle returns the old value. With `wr_en` low, no register changes.
- R8: With `cc_load` high, the flags take the sign class of the current result on the rising edge: N for bit 15 set, Z for all zero, P otherwise. Exactly one flag is set at any time.
- R9: With `cc_load` low, the flags keep their value.
- R10: `result_inc` equals `result` plus one, modulo 2^16.
- R11: The two read ports are independent and may address the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_a_addr | input | 3 | Register read for operand A |
| rd_b_addr | input | 3 | Register read for operand B |
| wr_addr | input | 3 | Destination register |
| op_sel | input | 2 | ALU function: 00 add, 01 and, 10 not, 11 pass A |
| b_imm_sel | input | 1 | 1 selects the immediate as operand B |
| imm | input | 5 | Two's-complement immediate |
| wr_en | input | 1 | Write the result into `wr_addr` at the clock edge |
| cc_load | input | 1 | Load the flags from the result at the clock edge |
| result | output | 16 | ALU result |
| result_inc | output | 16 | Result plus one |
| flag_n | output | 1 | Last loaded value was negative |
| flag_z | output | 1 | Last loaded value was zero |
| flag_p | output | 1 | Last loaded value was positive |

## Verification
The bench builds the slice with its default parameters: a 16-bit datapath, eight registers and a 5-bit immediate. At this size the sign bit and the wrap point are easy to reach. Repeated doubling produces 0x8000, and its complement produces 0x7FFF. Adding one to 0x7FFF then crosses from positive to negative, and adding one to 0xFFFF wraps to zero. The full immediate range, from -16 to +15, exercises the sign extension at both ends. A scoreboard model predicts the result, the incremented result and the flags for every cycle, and it covers the cases where a register is written and read in the same cycle or a write is suppressed.

// File: rtl/exec_pkg.sv
package exec_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_AND  = 2'b01,
    OP_NOT  = 2'b10,
    OP_PASS = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic pos;
  } cc_t;

  localparam cc_t CC_RESET = '{neg: 1'b0, zero: 1'b1, pos: 1'b0};

endpackage

// File: rtl/exec_rst_sync.sv
module exec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/exec_regfile.sv
module exec_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  localparam int ADDR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_a_addr,
  input  logic [ADDR_W-1:0] rd_b_addr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data
);

  logic [NREG-1:0][DATA_W-1:0] reg_q;
  logic [NREG-1:0]             reg_ce;

  // write decode: one clock enable per register
  always_comb begin
    reg_ce = '0;
    if (wr_en) begin
      reg_ce[wr_addr] = 1'b1;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[i] <= '0;
      end else if (reg_ce[i]) begin
        reg_q[i] <= wr_data;
      end
    end
  end

  // read ports see the registered state, so a same-cycle write is not visible
  always_comb begin
    rd_a_data = reg_q[rd_a_addr];
    rd_b_data = reg_q[rd_b_addr];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (reg_q[$past(wr_addr)] == $past(wr_data))); // R7

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_q)); // R7

endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 5
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] port_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              b_imm_sel,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] y_inc
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opnd_b;

  always_comb begin
    imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    opnd_b  = b_imm_sel ? imm_ext : port_b;
  end

  always_comb begin
    unique case (op)
      OP_ADD:  y = opnd_a + opnd_b;
      OP_AND:  y = opnd_a & opnd_b;
      OP_NOT:  y = ~opnd_a;
      OP_PASS: y = opnd_a;
      default: y = opnd_a;
    endcase
  end

  always_comb begin
    y_inc = y + {{(DATA_W-1){1'b0}}, 1'b1};
  end

  always_comb begin
    if (op == OP_NOT) begin
      AST_NOT_IGNORES_B: assert ((y & opnd_a) == '0); // R4
    end
    if (op == OP_PASS) begin
      AST_PASS_IS_A: assert (y == opnd_a); // R5
    end
  end

endmodule

// File: rtl/exec_cc.sv
module exec_cc
  import exec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] value,
  output cc_t               cc_q
);

  cc_t cc_d;

  // next-state: sign class of the offered value, or hold
  always_comb begin
    cc_d = cc_q;
    if (load) begin
      cc_d.neg  = value[DATA_W-1];
      cc_d.zero = (value == '0);
      cc_d.pos  = !value[DATA_W-1] && (value != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q <= CC_RESET;
    end else begin
      cc_q <= cc_d;
    end
  end

  AST_CC_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc_q) == 1); // R8

  AST_CC_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cc_q.zero == ($past(value) == '0))); // R8

  AST_CC_NEG_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cc_q.neg == $past(value[DATA_W-1]))); // R8

  AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cc_q)); // R9

endmodule

// File: rtl/exec_slice.sv
module exec_slice
  import exec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  parameter int IMM_W  = 5,
  localparam int ADDR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_a_addr,
  input  logic [ADDR_W-1:0] rd_b_addr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        op_sel,
  input  logic              b_imm_sel,
  input  logic [IMM_W-1:0]  imm,
  input  logic              wr_en,
  input  logic              cc_load,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] result_inc,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_p
);

  logic              rst_core_n;
  logic [DATA_W-1:0] rd_a_data;
  logic [DATA_W-1:0] rd_b_data;
  logic [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0] alu_y_inc;
  alu_op_e           op;
  cc_t               cc;

  assign op = alu_op_e'(op_sel);

  exec_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  exec_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .rd_a_addr (rd_a_addr),
    .rd_b_addr (rd_b_addr),
    .wr_addr   (wr_addr),
    .wr_data   (alu_y),
    .wr_en     (wr_en),
    .rd_a_data (rd_a_data),
    .rd_b_data (rd_b_data)
  );

  exec_alu #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_alu (
    .opnd_a    (rd_a_data),
    .port_b    (rd_b_data),
    .imm       (imm),
    .b_imm_sel (b_imm_sel),
    .op        (op),
    .y         (alu_y),
    .y_inc     (alu_y_inc)
  );

  exec_cc #(.DATA_W(DATA_W)) u_cc (
    .clk   (clk),
    .rst_n (rst_core_n),
    .load  (cc_load),
    .value (alu_y),
    .cc_q  (cc)
  );

  assign result     = alu_y;
  assign result_inc = alu_y_inc;
  assign flag_n     = cc.neg;
  assign flag_z     = cc.zero;
  assign flag_p     = cc.pos;

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (result_inc - result) == {{(DATA_W-1){1'b0}}, 1'b1}); // R10

endmodule

// File: tb/sim_exec_slice.sv
module sim_exec_slice;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    logic [15:0] res;
    logic [15:0] inc;
    logic [2:0]  cc;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [2:0]  rd_a_addr, rd_b_addr, wr_addr;
  logic [1:0]  op_sel;
  logic        b_imm_sel, wr_en, cc_load;
  logic [4:0]  imm;
  logic [15:0] result, result_inc;
  logic        flag_n, flag_z, flag_p;

  exp_t        sb_q[$];
  logic [15:0] m_reg [8];
  logic [2:0]  m_cc;
  int          checks;
  int          errors;
  bit          done;

  exec_slice u0 (
    .clk(clk), .rst_n(rst_n), .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
    .wr_addr(wr_addr), .op_sel(op_sel), .b_imm_sel(b_imm_sel), .imm(imm),
    .wr_en(wr_en), .cc_load(cc_load), .result(result), .result_inc(result_inc),
    .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] sign_class(logic [15:0] v);
    if (v[15])          return 3'b100;
    else if (v == 16'h0) return 3'b010;
    else                 return 3'b001;
  endfunction

  // driver: applies one operation at a falling edge and predicts its outputs
  task automatic drive(input int a, input int b, input int w, input logic [1:0] op,
                       input logic ui, input logic [4:0] im, input logic we,
                       input logic cl, input string tag);
    logic [15:0] bv, y;
    exp_t e;
    @(negedge clk);
    rd_a_addr = 3'(a); rd_b_addr = 3'(b); wr_addr = 3'(w);
    op_sel = op; b_imm_sel = ui; imm = im; wr_en = we; cc_load = cl;
    bv = ui ? {{11{im[4]}}, im} : m_reg[b];
    case (op)
      2'b00:   y = m_reg[a] + bv;
      2'b01:   y = m_reg[a] & bv;
      2'b10:   y = ~m_reg[a];
      default: y = m_reg[a];
    endcase
    e.res = y; e.inc = y + 16'd1; e.cc = m_cc; e.tag = tag;
    sb_q.push_back(e);
    if (we) m_reg[w] = y;
    if (cl) m_cc = sign_class(y);
  endtask

  task automatic cmp(input string what, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops one prediction per cycle, sampled mid-low-phase
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        cmp("result", e.tag, result, e.res);
        cmp("result_inc", e.tag, result_inc, e.inc);
        cmp("flags", e.tag, {13'd0, flag_n, flag_z, flag_p}, {13'd0, e.cc});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    for (int i = 0; i < 8; i++) m_reg[i] = 16'h0;
    m_cc = 3'b010;
    rst_n = 1'b0;
    rd_a_addr = '0; rd_b_addr = '0; wr_addr = '0; op_sel = '0;
    b_imm_sel = 1'b0; imm = '0; wr_en = 1'b0; cc_load = 1'b0;
    repeat (3) @(posedge clk);
    // R1: outputs while reset is still applied
    #(CLK_PERIOD/4);
    cmp("flags_in_reset", "R1", {13'd0, flag_n, flag_z, flag_p}, 16'h0002);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: all registers zero, flags Z
    for (int i = 0; i < 8; i++) drive(i, 0, 0, 2'b11, 0, 5'd0, 0, 0, "R1");
    // R6: immediates, positive and negative
    drive(0, 0, 1, 2'b00, 1, 5'd5, 1, 1, "R6");
    drive(0, 0, 2, 2'b00, 1, 5'b11101, 1, 1, "R6");
    // R2/R8: 5 + -3 = 2, flags go from N to P
    drive(1, 2, 3, 2'b00, 0, 5'd0, 1, 1, "R2");
    // R4: NOT of r0 with B pointing at a nonzero register
    drive(0, 1, 4, 2'b10, 0, 5'd0, 1, 1, "R4");
    drive(0, 2, 4, 2'b10, 1, 5'd9, 1, 0, "R4");
    // R2: build 0x8000 by doubling
    drive(0, 0, 5, 2'b00, 1, 5'd1, 1, 0, "R6");
    for (int k = 0; k < 15; k++) drive(5, 5, 5, 2'b00, 0, 5'd0, 1, 1, "R2");
    drive(5, 0, 6, 2'b10, 0, 5'd0, 1, 1, "R4");
    drive(6, 0, 7, 2'b00, 1, 5'd1, 1, 1, "R2");
    // R2/R10: 0xFFFF + 1 wraps to zero, flags Z
    drive(4, 0, 0, 2'b00, 1, 5'd1, 0, 1, "R2");
    drive(4, 0, 0, 2'b11, 0, 5'd0, 0, 1, "R10");
    // R3: AND with register and with immediate -16
    drive(2, 1, 3, 2'b01, 0, 5'd0, 0, 1, "R3");
    drive(4, 0, 3, 2'b01, 1, 5'b10000, 1, 1, "R3");
    drive(3, 6, 3, 2'b01, 0, 5'd0, 0, 1, "R3");
    // R5/R9: pass with flags held, then loaded
    drive(7, 0, 0, 2'b11, 0, 5'd0, 0, 0, "R9");
    drive(1, 0, 0, 2'b11, 0, 5'd0, 0, 0, "R9");
    drive(7, 0, 0, 2'b11, 0, 5'd0, 0, 1, "R5");
    drive(6, 0, 0, 2'b11, 0, 5'd0, 0, 1, "R5");
    // R7: same-cycle read sees old value, then the new one
    drive(1, 0, 1, 2'b00, 1, 5'd1, 1, 0, "R7");
    drive(1, 0, 1, 2'b11, 0, 5'd0, 0, 0, "R7");
    // R7: suppressed write leaves register intact
    drive(1, 0, 1, 2'b00, 1, 5'd7, 0, 0, "R7");
    drive(1, 0, 1, 2'b11, 0, 5'd0, 0, 0, "R7");
    // R11: both ports on one register
    drive(3, 3, 2, 2'b00, 0, 5'd0, 1, 1, "R11");
    drive(2, 2, 0, 2'b01, 0, 5'd0, 0, 1, "R11");
    // R6: immediate limits +15 and -16
    drive(0, 7, 0, 2'b00, 1, 5'd15, 0, 1, "R6");
    drive(0, 7, 0, 2'b00, 1, 5'b10000, 0, 1, "R6");
    drive(0, 0, 0, 2'b11, 0, 5'd0, 0, 0, "R6");

    // drain scoreboard
    repeat (3) @(negedge clk);
    wr_en = 1'b0; cc_load = 1'b0;
    repeat (2) @(posedge clk);
    cmp("scoreboard_empty", "R1", 16'(sb_q.size()), 16'd0);
    finish_run();
  end

endmodule